// File: doc/BRIEF.md
# Cascade Sigma-Delta Error-Cancellation Combiner

This block is the digital recombination network behind a fourth-order cascade sigma-delta modulator built from a second-order front stage and two first-order stages. On every modulator sample it takes one bit from each stage and maps each bit to a value of plus or minus one. It passes the first-stage value through a two-sample delay, the second-stage value through a double first difference and a one-sample delay, and the third-stage value through a triple first difference. It then weights the later paths by power-of-two coefficients and adds the three paths.

When the analog stages follow the ideal loop equations, the sum cancels the quantization errors of the first two stages. The output word then holds the modulator input delayed by four samples, plus the third stage's error scaled by its coefficient and shaped by the fourth power of a first difference. The word goes on to a decimation filter. A sample strobe qualifies the stage bits. The combiner's state advances only on strobed cycles, and the output word is registered with a matching valid flag.

Top module: `sdc_cancel`

## Requirements
- R1: While reset is asserted the output word is 0 and the output valid is low. All delay and difference history clears to zero, so the first outputs after reset are computed as if every earlier stage value were 0.
- R2: The output valid is high in exactly the clock cycle after each cycle in which the sample strobe is high, and low otherwise.
- R3: A stage bit of 1 counts as +1 and a bit of 0 counts as -1. A constant all-ones input settles to an output of +1, and a constant all-zeros input settles to -1.
- R4: For sample n, the output word equals s1(n-2) + 2^C2_SHIFT*(s2(n-1) - 2*s2(n-2) + s2(n-3)) + 2^C3_SHIFT*(s3(n) - 3*s3(n-1) + 3*s3(n-2) - s3(n-3)). Here s1, s2 and s3 are the mapped values of bit_a, bit_b and bit_c.
- R5: Fed by ideal integer stages, the output times the stage-one full scale F equals the input from four samples earlier plus the fourth difference of the third-stage error. No first- or second-stage error term remains. The second and third stages have full scales F*2^C2_SHIFT and F*2^C3_SHIFT.
- R6: A change on the second-stage bit alone reaches the output one sample later, scaled by 2^C2_SHIFT. A change on the third-stage bit alone reaches the output in the same sample, scaled by 2^C3_SHIFT.
- R7: The output word never leaves the range +-(1 + 4*2^C2_SHIFT + 8*2^C3_SHIFT), and the width of the word holds that range. With the default shifts, alternating bit patterns reach both +41 and -41.
- R8: Stage bits presented while the strobe is low have no effect on any later output.
- R9: The output word holds its value through every cycle in which the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| smp_vld | input | 1 | Stage bits are valid this cycle |
| bit_a | input | 1 | Second-order front stage bit |
| bit_b | input | 1 | First first-order stage bit |
| bit_c | input | 1 | Last first-order stage bit |
| word_vld | output | 1 | Output word updated this cycle |
| word_out | output | OUT_W | Signed recombined word (7 bits by default) |

## Verification
Integer models of the three stages drive the block with zero, positive and negative constant inputs, a ramp and a triangle wave. The predicted output is built only from the input and the third-stage error, so any leftover of the first- or second-stage errors, any wrong path delay, and any coefficient error all show up as a mismatch. Raw bit patterns cover the rest. Constant ones and zeros separate the bit polarity from the differentiators. Alternating patterns drive the output to both extremes of its range. Single-bit toggles on one stage, with idle cycles carrying junk bits, show each path's delay and weight and prove that unstrobed inputs are ignored.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // Largest output magnitude for +-1 stage values:
  // delayed front value 1, double difference up to 4, triple difference up to 8.
  function automatic int out_bound(input int c2_shift, input int c3_shift);
    return 1 + (4 << c2_shift) + (8 << c3_shift);
  endfunction

  // Signed width holding +-out_bound.
  function automatic int out_width(input int c2_shift, input int c3_shift);
    return $clog2(out_bound(c2_shift, c3_shift) + 1) + 1;
  endfunction

  typedef logic signed [1:0] pm1_t;

  function automatic pm1_t to_pm1(input logic b);
    return b ? 2'sd1 : -2'sd1;
  endfunction

endpackage

// File: rtl/sdc_tap_delay.sv
module sdc_tap_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] d,
  output logic signed [W-1:0] q
);

  logic signed [W-1:0] tap_q [DEPTH];
  logic signed [W-1:0] tap_d [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
      if (i == 0) begin : g_head
        always_comb tap_d[i] = en ? d : tap_q[i];
      end else begin : g_body
        always_comb tap_d[i] = en ? tap_q[i-1] : tap_q[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q[i] <= '0;
        else        tap_q[i] <= tap_d[i];
      end
    end
  endgenerate

  assign q = tap_q[DEPTH-1];

endmodule

// File: rtl/sdc_diff_chain.sv
module sdc_diff_chain #(
  parameter int  W     = 2,
  parameter int  ORDER = 2,
  localparam int OW    = W + ORDER
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [W-1:0]  d,
  output logic signed [OW-1:0] q
);

  // node[k] is the k-th first difference of d; prev_q[k] keeps node[k]
  // from the previous enabled sample.
  logic signed [OW-1:0] node   [ORDER+1];
  logic signed [OW-1:0] prev_q [ORDER];
  logic signed [OW-1:0] prev_d [ORDER];

  assign node[0] = OW'(d);

  generate
    for (genvar k = 0; k < ORDER; k++) begin : g_stage
      always_comb begin
        node[k+1] = node[k] - prev_q[k];
        prev_d[k] = en ? node[k] : prev_q[k];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q[k] <= '0;
        else        prev_q[k] <= prev_d[k];
      end
    end
  endgenerate

  assign q = node[ORDER];

endmodule

// File: rtl/sdc_cancel.sv
module sdc_cancel
  import sdc_pkg::*;
#(
  parameter int  C2_SHIFT = 1,
  parameter int  C3_SHIFT = 2,
  localparam int OUT_W    = out_width(C2_SHIFT, C3_SHIFT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic                    bit_a,
  input  logic                    bit_b,
  input  logic                    bit_c,
  output logic                    word_vld,
  output logic signed [OUT_W-1:0] word_out
);

  localparam int A_DLY  = 2;
  localparam int B_ORD  = 2;
  localparam int B_DLY  = 1;
  localparam int C_ORD  = 3;
  localparam int PM_W   = 2;
  localparam int B_W    = PM_W + B_ORD;
  localparam int C_W    = PM_W + C_ORD;

  pm1_t s_a, s_b, s_c;

  always_comb begin
    s_a = to_pm1(bit_a);
    s_b = to_pm1(bit_b);
    s_c = to_pm1(bit_c);
  end

  // Front stage: pure delay.
  logic signed [PM_W-1:0] a_path;
  sdc_tap_delay #(.W(PM_W), .DEPTH(A_DLY)) u_dly_a (
    .clk(clk), .rst_n(rst_n), .en(smp_vld), .d(s_a), .q(a_path)
  );

  // Middle stage: double difference then one-sample delay.
  logic signed [B_W-1:0] b_diff, b_path;
  sdc_diff_chain #(.W(PM_W), .ORDER(B_ORD)) u_dif_b (
    .clk(clk), .rst_n(rst_n), .en(smp_vld), .d(s_b), .q(b_diff)
  );
  sdc_tap_delay #(.W(B_W), .DEPTH(B_DLY)) u_dly_b (
    .clk(clk), .rst_n(rst_n), .en(smp_vld), .d(b_diff), .q(b_path)
  );

  // Last stage: triple difference.
  logic signed [C_W-1:0] c_path;
  sdc_diff_chain #(.W(PM_W), .ORDER(C_ORD)) u_dif_c (
    .clk(clk), .rst_n(rst_n), .en(smp_vld), .d(s_c), .q(c_path)
  );

  // Weighted sum, next-state and register processes.
  logic signed [OUT_W-1:0] sum_d, word_d;
  logic                    vld_d;

  always_comb begin
    sum_d  = OUT_W'(a_path)
           + (OUT_W'(b_path) <<< C2_SHIFT)
           + (OUT_W'(c_path) <<< C3_SHIFT);
    word_d = smp_vld ? sum_d : word_out;
    vld_d  = smp_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_out <= word_d;
      word_vld <= vld_d;
    end
  end

endmodule

// File: rtl/sdc_cancel_chk.sv
module sdc_cancel_chk #(
  parameter int OUT_W = 7,
  parameter int BOUND = 41
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_vld,
  input logic                    word_vld,
  input logic signed [OUT_W-1:0] word_out
);

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> word_vld);  // R2

  AST_VLD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !word_vld);  // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> (word_out <= BOUND && word_out >= -BOUND));  // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(word_out));  // R9

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (word_out == '0 && !word_vld);  // R1
    end
  end

endmodule

bind sdc_cancel sdc_cancel_chk #(
  .OUT_W(OUT_W),
  .BOUND(sdc_pkg::out_bound(C2_SHIFT, C3_SHIFT))
) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
  .word_vld(word_vld), .word_out(word_out)
);

// File: tb/sdc_cancel_tb.sv
module sdc_cancel_tb_top;

  localparam int    C2S   = 1;
  localparam int    C3S   = 2;
  localparam int    OW    = sdc_pkg::out_width(C2S, C3S);
  localparam int    BOUND = sdc_pkg::out_bound(C2S, C3S);
  localparam longint F    = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0, bit_a = 1'b0, bit_b = 1'b0, bit_c = 1'b0;
  logic word_vld;
  logic signed [OW-1:0] word_out;

  always #5 clk = ~clk;

  sdc_cancel #(.C2_SHIFT(C2S), .C3_SHIFT(C3S)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .bit_a(bit_a), .bit_b(bit_b), .bit_c(bit_c),
    .word_vld(word_vld), .word_out(word_out)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  longint exp_q[$];
  string  req_q[$];
  longint last_out = 0, max_seen = 0, min_seen = 0;

  // Raw-mode history of mapped values, index 0 = current sample.
  int p1[3], p2[4], p3[4];
  // Stage-model state.
  longint xh[5];
  longint e1m1, e1m2, u2m1, e2m1, u3m1, e3m1, e3h[5];

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on each valid output, checks hold otherwise.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (word_vld) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected word", longint'(word_out), 0);
        end else begin
          longint e;
          string  r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(longint'(word_out) == e, r, longint'(word_out), e);
        end
        if (longint'(word_out) > max_seen) max_seen = longint'(word_out);
        if (longint'(word_out) < min_seen) min_seen = longint'(word_out);
      end else begin
        check(longint'(word_out) == last_out, "R9 hold", longint'(word_out), last_out);
      end
      last_out = longint'(word_out);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smp_vld = 1'b0;
    @(negedge clk);
    check(word_out == '0, "R1 reset word", longint'(word_out), 0);
    check(word_vld == 1'b0, "R1 reset valid", longint'(word_vld), 0);
    for (int i = 0; i < 4; i++) begin
      if (i < 3) p1[i] = 0;
      p2[i] = 0; p3[i] = 0;
    end
    for (int i = 0; i < 5; i++) begin xh[i] = 0; e3h[i] = 0; end
    e1m1 = 0; e1m2 = 0; u2m1 = 0; e2m1 = 0; u3m1 = 0; e3m1 = 0;
    last_out = 0; max_seen = 0; min_seen = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive(input logic a, input logic b, input logic c);
    smp_vld = 1'b1; bit_a = a; bit_b = b; bit_c = c;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  // Idle cycles with junk on the stage bits (R8).
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      smp_vld = 1'b0;
      bit_a = ~bit_a; bit_b = (i % 2) == 0; bit_c = ~bit_c;
      @(negedge clk);
    end
  endtask

  // Raw bits; expected from the R4 formula.
  task automatic raw_sample(input logic a, input logic b, input logic c, input string req);
    longint e;
    p1[2] = p1[1]; p1[1] = p1[0]; p1[0] = a ? 1 : -1;
    for (int i = 3; i > 0; i--) begin p2[i] = p2[i-1]; p3[i] = p3[i-1]; end
    p2[0] = b ? 1 : -1;
    p3[0] = c ? 1 : -1;
    e = p1[2]
      + (longint'(p2[1] - 2*p2[2] + p2[3]) << C2S)
      + (longint'(p3[0] - 3*p3[1] + 3*p3[2] - p3[3]) << C3S);
    exp_q.push_back(e);
    req_q.push_back(req);
    drive(a, b, c);
  endtask

  // Ideal integer stages; expected from input and last-stage error only (R5).
  task automatic model_sample(input longint x, input string req);
    longint v1, y1, e1, u2, v2, y2, e2, u3, v3, y3, e3, num;
    logic b1, b2, b3;
    for (int i = 4; i > 0; i--) xh[i] = xh[i-1];
    xh[0] = x;
    v1 = xh[2] - 2*e1m1 + e1m2;
    b1 = (v1 >= 0);
    y1 = b1 ? F : -F;
    e1 = y1 - v1;
    u2 = -e1;
    v2 = u2m1 - e2m1;
    b2 = (v2 >= 0);
    y2 = b2 ? (F << C2S) : -(F << C2S);
    e2 = y2 - v2;
    u3 = -e2;
    v3 = u3m1 - e3m1;
    b3 = (v3 >= 0);
    y3 = b3 ? (F << C3S) : -(F << C3S);
    e3 = y3 - v3;
    e1m2 = e1m1; e1m1 = e1; u2m1 = u2; e2m1 = e2; u3m1 = u3; e3m1 = e3;
    for (int i = 4; i > 0; i--) e3h[i] = e3h[i-1];
    e3h[0] = e3;
    num = xh[4] + e3h[0] - 4*e3h[1] + 6*e3h[2] - 4*e3h[3] + e3h[4];
    check(num % F == 0, "R5 integral", num % F, 0);
    exp_q.push_back(num / F);
    req_q.push_back(req);
    drive(b1, b2, b3);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 pending words", exp_q.size(), 0);
  endtask

  initial begin
    do_reset();

    // R1: first sample uses zero history; R3: polarity and settling.
    raw_sample(1, 1, 1, "R1 first sample");
    for (int i = 0; i < 7; i++) raw_sample(1, 1, 1, "R3 all ones");
    for (int i = 0; i < 8; i++) raw_sample(0, 0, 0, "R3 all zeros");
    drain();
    check(last_out == -1, "R3 settled zeros", last_out, -1);

    // R7: alternating patterns reach both range limits.
    do_reset();
    for (int n = 0; n < 16; n++)
      raw_sample((n % 2) == 0, (n % 2) == 1, (n % 2) == 0, "R7 extreme");
    drain();
    check(max_seen == BOUND, "R7 max", max_seen, BOUND);
    check(min_seen == -BOUND, "R7 min", min_seen, -BOUND);

    // R6: single-stage toggles; R8: junk during idle gaps.
    do_reset();
    for (int i = 0; i < 5; i++) raw_sample(1, 1, 1, "R6 settle");
    raw_sample(1, 0, 1, "R6 middle step");
    for (int i = 0; i < 5; i++) raw_sample(1, 0, 1, "R6 middle tail");
    raw_sample(1, 0, 0, "R6 last step");
    for (int i = 0; i < 5; i++) raw_sample(1, 0, 0, "R6 last tail");
    for (int n = 0; n < 24; n++) begin
      raw_sample(((n / 3) % 2) == 0, (n % 5) < 2, (n % 3) == 1, "R8 gapped");
      idle(1 + n % 3);
    end
    raw_sample(1, 1, 1, "R4 after gaps");
    drain();

    // R5: stage models under several inputs, some with gaps.
    begin
      longint pats[4];
      pats[0] = 0; pats[1] = 300; pats[2] = -450; pats[3] = 120;
      for (int p = 0; p < 4; p++) begin
        do_reset();
        for (int n = 0; n < 60; n++) begin
          model_sample(pats[p], "R5 constant");
          if (p == 3 && n % 4 == 0) idle(2);
        end
        drain();
      end
    end
    do_reset();
    for (int n = 0; n < 100; n++) model_sample(-500 + 10*n, "R5 ramp");
    drain();
    do_reset();
    for (int n = 0; n < 120; n++) begin
      longint t;
      t = (n % 40) < 20 ? (n % 40) * 25 - 250 : 750 - (n % 40) * 25;
      model_sample(t, "R5 triangle");
      if (n % 7 == 3) idle(1);
    end
    drain();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule